// File: doc/BRIEF.md
# Pipelined Last-Byte Detector

This block tracks how far a byte buffer has been filled and drained. It holds a write counter and a read counter, both 11 bits wide by default. It raises a registered flag when the write count is exactly one or two ahead of the read count, so the consumer knows the next byte it takes is the final one. An odd-count mode input chooses the distance. When the mode is low, the flag means the write count equals the read count plus one. When the mode is high, it means the write count equals the read count plus two. All counter arithmetic wraps modulo 2^CNT_W.

No adder sits in front of the equality compare. Read-side copies of the counter start at offsets 0, 1 and 2 and step together. A separate copy of the write counter feeds only the comparator, so the comparator's fan-out stays off the primary counter's feedback loop. The compare is cut into SLICE_W-bit slices. Each slice has its own register, and a final registered AND merges the slices. As a result, the flag follows the counters with a fixed latency of two clock cycles, and this includes the cycles that follow a load.

Top module: `last_byte_detector`

## Requirements
- R1: A synchronous active-high reset sets the write count to 0, sets the read copies to 0, 1 and 2, clears the registered mode and every compare register, and holds `last_byte` at 0.
- R2: The write count increases by 1 on each clock edge where `wr_en` is 1 and `load_en` is 0.
- R3: The read copies at offsets 0, 1 and 2 step together by 1 on each edge where `rd_en` is 1 and `load_en` is 0, so they always differ by exactly 1 and 2 from the base read count.
- R4: When `load_en` is 1, the write count takes `load_wr` and the read count takes `load_rd`, with the read copies at `load_rd`+1 and `load_rd`+2. Load takes priority over `wr_en` and `rd_en`.
- R5: When the registered mode is 0, the flag evaluates to 1 exactly when the write count equals the read count plus 1.
- R6: When the registered mode is 1, the flag evaluates to 1 exactly when the write count equals the read count plus 2.
- R7: `last_byte` sampled after clock edge k+2 gives the R5/R6 result for the counters and for `odd_mode` as registered at edge k. The latency is a fixed two cycles, and this also holds right after a load.
- R8: If `wr_en` and `rd_en` are both 1 in the same cycle, both counters advance.
- R9: Counters wrap from 2^CNT_W−1 to 0, and the flag's equality holds across the wrap. For example, with read count 2047 and write count 0 in mode 0, the flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Advance the write count |
| rd_en | input | 1 | Advance all read copies |
| odd_mode | input | 1 | 1: flag on distance two; 0: flag on distance one |
| load_en | input | 1 | Load both counters from the load inputs |
| load_wr | input | CNT_W | Value loaded into the write count |
| load_rd | input | CNT_W | Value loaded into the read count |
| last_byte | output | 1 | Registered last-byte flag, two cycles behind the counters |

## Verification
The bench compares the flag with a reference counter model on every cycle, applying the two-cycle delay. Write-heavy and read-heavy random traffic is biased to keep the counters within a few counts of each other. This exercises the distances 0, 1, 2 and 3, which separate a correct offset from an off-by-one in either read copy. The mode is toggled during traffic to show that it is registered together with the counters. Directed loads near 2047 test the carry across the wrap and across slice boundaries. Loads made while the flag is up show that the old result holds for exactly two cycles. Cycles with simultaneous read and write, and loads made while the enables are also high, separate correct counter updates from dropped or misprioritised ones.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
   localparam int unsigned LBD_CNT_W_DEF   = 11;
   localparam int unsigned LBD_SLICE_W_DEF = 3;
   localparam int unsigned LBD_RD_COPIES   = 3;

   function automatic int unsigned lbd_num_slices(input int unsigned w, input int unsigned s);
      return (w + s - 1) / s;
   endfunction
endpackage

// File: rtl/lbd_offset_counter.sv
module lbd_offset_counter #(
   parameter int unsigned W      = 11,
   parameter int unsigned OFFSET = 0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         step_en,
   output logic [W-1:0] cnt_q
);
   localparam logic [W-1:0] OFS = W'(OFFSET);

   logic [W-1:0] cnt_nxt;

   always_comb begin
      if (load_en)      cnt_nxt = load_val + OFS;
      else if (step_en) cnt_nxt = cnt_q + {{(W-1){1'b0}}, 1'b1};
      else              cnt_nxt = cnt_q;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= OFS;
      else     cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/lbd_slice_eq.sv
module lbd_slice_eq #(
   parameter int unsigned W  = 11,
   parameter int unsigned SW = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] wr_val,
   input  logic [W-1:0] rd_near,
   input  logic [W-1:0] rd_far,
   input  logic         use_far,
   output logic         match_q
);
   localparam int unsigned NSL = lbd_pkg::lbd_num_slices(W, SW);

   logic [NSL-1:0] slice_eq_q;

   for (genvar s = 0; s < NSL; s++) begin : g_slice
      localparam int unsigned LO = s * SW;
      localparam int unsigned HI = ((LO + SW) > W) ? (W - 1) : (LO + SW - 1);
      logic hit_near, hit_far;
      assign hit_near = (wr_val[HI:LO] == rd_near[HI:LO]);
      assign hit_far  = (wr_val[HI:LO] == rd_far[HI:LO]);
      always_ff @(posedge clk) begin
         if (rst) slice_eq_q[s] <= 1'b0;
         else     slice_eq_q[s] <= use_far ? hit_far : hit_near;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) match_q <= 1'b0;
      else     match_q <= &slice_eq_q;
   end

   // R1: one cycle after a reset edge the merged flag is low
   a_r1_flag_clear: assert property (@(posedge clk) rst |=> !match_q)
      else $error("flag not cleared by reset");
endmodule

// File: rtl/last_byte_detector.sv
module last_byte_detector #(
   parameter int unsigned CNT_W   = lbd_pkg::LBD_CNT_W_DEF,
   parameter int unsigned SLICE_W = lbd_pkg::LBD_SLICE_W_DEF
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic             odd_mode,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_wr,
   input  logic [CNT_W-1:0] load_rd,
   output logic             last_byte
);
   localparam int unsigned NCOPY = lbd_pkg::LBD_RD_COPIES;
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] TWO = ONE + ONE;

   if (CNT_W < 2 || SLICE_W < 1 || SLICE_W > CNT_W) begin : g_bad_params
      $error("last_byte_detector: CNT_W must be >= 2 and SLICE_W in 1..CNT_W");
   end

   logic [CNT_W-1:0] wr_cnt;
   logic [CNT_W-1:0] wr_cmp;
   logic [CNT_W-1:0] rd_copy [NCOPY];
   logic             odd_q;

   lbd_offset_counter #(.W(CNT_W), .OFFSET(0)) i_wr_main (
      .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_wr),
      .step_en(wr_en), .cnt_q(wr_cnt));

   lbd_offset_counter #(.W(CNT_W), .OFFSET(0)) i_wr_cmp (
      .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_wr),
      .step_en(wr_en), .cnt_q(wr_cmp));

   for (genvar i = 0; i < NCOPY; i++) begin : g_rd
      lbd_offset_counter #(.W(CNT_W), .OFFSET(i)) i_rd (
         .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_rd),
         .step_en(rd_en), .cnt_q(rd_copy[i]));
   end

   always_ff @(posedge clk) begin
      if (rst) odd_q <= 1'b0;
      else     odd_q <= odd_mode;
   end

   lbd_slice_eq #(.W(CNT_W), .SW(SLICE_W)) i_cmp (
      .clk(clk), .rst(rst), .wr_val(wr_cmp), .rd_near(rd_copy[1]),
      .rd_far(rd_copy[2]), .use_far(odd_q), .match_q(last_byte));

   logic [1:0] live_q;
   always_ff @(posedge clk) begin
      if (rst) live_q <= 2'b00;
      else     live_q <= {live_q[0], 1'b1};
   end

   // R3: read copies stay at fixed offsets from the base read count
   a_r3_copy_offsets: assert property (@(posedge clk) disable iff (rst)
      (rd_copy[1] == rd_copy[0] + ONE) && (rd_copy[2] == rd_copy[0] + TWO))
      else $error("read copies drifted");

   // R2 and R8: write count steps on wr_en
   a_r2_wr_step: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !load_en) |=> (wr_cnt == $past(wr_cnt) + ONE))
      else $error("write count did not step");

   // R8: read count steps on rd_en, also alongside a write
   a_r8_rd_step: assert property (@(posedge clk) disable iff (rst)
      (rd_en && !load_en) |=> (rd_copy[0] == $past(rd_copy[0]) + ONE))
      else $error("read count did not step");

   // R4: load wins over enables
   a_r4_load: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (wr_cnt == $past(load_wr)) && (rd_copy[0] == $past(load_rd)))
      else $error("load not taken");

   // R7: flag equals the distance test on primary counters two edges back
   a_r7_flag_latency: assert property (@(posedge clk) disable iff (rst)
      live_q[1] |-> (last_byte == ($past(odd_q, 2)
         ? ($past(wr_cnt, 2) == $past(rd_copy[0], 2) + TWO)
         : ($past(wr_cnt, 2) == $past(rd_copy[0], 2) + ONE))))
      else $error("flag mismatch against counters");
endmodule

// File: tb/test_last_byte_detector.sv
module test_last_byte_detector;
   localparam int unsigned W = 11;
   typedef logic [W-1:0] cnt_t;

   logic clk = 1'b0;
   logic rst, wr_en, rd_en, odd_mode, load_en;
   cnt_t load_wr, load_rd;
   logic last_byte;

   int vectors = 0;
   int miscompares = 0;

   always #5 clk = ~clk;

   last_byte_detector i_last_byte_detector (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .odd_mode(odd_mode),
      .load_en(load_en), .load_wr(load_wr), .load_rd(load_rd), .last_byte(last_byte));

   // reference state after each edge: write count, read count, registered mode
   cnt_t m_w, m_r;
   logic m_o;
   cnt_t p1_w, p1_r, p2_w, p2_r;
   logic p1_o, p2_o;

   function automatic logic exp_flag(input cnt_t w, input cnt_t r, input logic o);
      return o ? (w == cnt_t'(r + 2)) : (w == cnt_t'(r + 1));
   endfunction

   task automatic check(input logic act, input logic exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: last_byte=%0b expected %0b (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; wr_en = 0; rd_en = 0; odd_mode = 0; load_en = 0;
      load_wr = '0; load_rd = '0;
      repeat (2) @(posedge clk);
      m_w = '0; m_r = '0; m_o = 1'b0;
      p1_w = '0; p1_r = '0; p1_o = 1'b0;
      p2_w = '0; p2_r = '0; p2_o = 1'b0;
      @(negedge clk);
      check(last_byte, 1'b0, "R1 reset");
      rst = 1'b0;
   endtask

   // one cycle: drive at negedge, update model at posedge, check at next negedge
   task automatic step(input logic w, input logic r, input logic o, input logic ld,
                       input cnt_t lw, input cnt_t lr, input string tag);
      logic e;
      string t;
      wr_en = w; rd_en = r; odd_mode = o; load_en = ld; load_wr = lw; load_rd = lr;
      @(posedge clk);
      e = exp_flag(p2_w, p2_r, p2_o);
      p2_w = p1_w; p2_r = p1_r; p2_o = p1_o;
      if (ld) begin m_w = lw; m_r = lr; end          // R4 load priority
      else begin
         if (w) m_w = m_w + 1'b1;                      // R2, R9 wrap
         if (r) m_r = m_r + 1'b1;                      // R3, R8 both together
      end
      m_o = o;
      p1_w = m_w; p1_r = m_r; p1_o = m_o;
      @(negedge clk);
      t = (tag != "") ? tag : (e ? "R7 flag set" : "R7 flag clear");
      t = {t, (p2_o ? " R6" : " R5")};
      check(last_byte, e, t);
   endtask

   task automatic idle(input int n, input logic o, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, o, 0, '0, '0, tag);
   endtask

   initial begin
      #(200000 * 10);
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd20110523);
      do_reset();

      // R5: distance one in even mode
      step(0, 0, 0, 1, 11'd5, 11'd4, "R4 load");
      idle(3, 0, "R5 distance one");
      // R6: same counters in odd mode give no flag, then distance two does
      idle(3, 1, "R6 distance one odd");
      step(0, 0, 1, 1, 11'd6, 11'd4, "R4 load odd");
      idle(3, 1, "R6 distance two");
      // R7: load while flag high; old result holds exactly two cycles
      step(1, 1, 1, 1, 11'd100, 11'd10, "R7 load latency");
      idle(3, 1, "R7 after load");
      // R8: simultaneous read and write keeps distance
      step(0, 0, 0, 1, 11'd21, 11'd20, "R4 load");
      for (int i = 0; i < 6; i++) step(1, 1, 0, 0, '0, '0, "R8 both enables");
      idle(2, 0, "R8 settle");
      // R9: wrap across 2047 -> 0 in both modes
      step(0, 0, 0, 1, 11'd0, 11'd2047, "R9 wrap load");
      idle(3, 0, "R9 wrap even");
      step(0, 0, 1, 1, 11'd1, 11'd2047, "R9 wrap load odd");
      idle(3, 1, "R9 wrap odd");
      step(0, 0, 0, 1, 11'd2044, 11'd2043, "R4 load");
      for (int i = 0; i < 8; i++) step(1, 1, 0, 0, '0, '0, "R9 walk through wrap");

      // random traffic, distance kept small
      for (int i = 0; i < 6000; i++) begin
         cnt_t d;
         logic w, r, o, ld;
         cnt_t lw, lr;
         d = m_w - m_r;
         w = (d < 4) ? (($urandom % 4) != 0) : (($urandom % 4) == 0);
         r = (d > 0 && d < 11'd1000) ? (($urandom % 2) != 0) : (($urandom % 6) == 0);
         o = (($urandom % 24) == 0) ? ~m_o : m_o;
         ld = (($urandom % 300) == 0);
         lw = cnt_t'(2040 + ($urandom % 8));
         lr = lw - cnt_t'($urandom % 4);
         step(w, r, o, ld, lw, lr, "");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule